// File: doc/BRIEF.md
# DSI PHY Configuration Sequencer

This block brings up a DSI physical layer by walking through a fixed, partly conditional list of byte-wide register writes. A one-cycle start pulse latches the operating point: the lane bit rate in Mbps, a high-speed frequency-range code chosen by a lookup elsewhere, the PLL input and feedback divider values, and a flag that marks the primary instance. From the lane rate the block derives a 3-bit VCO range selection. It then presents one address/data pair at a time on a valid/ready write port, normally wired to the PHY test-interface master.

Each write is held until the downstream side accepts it. The next write is presented in the following cycle. Registers that are split into low and high halves are written twice, each time with a different half-select enable. The five PLL writes are issued only on the primary instance. A single-cycle done pulse follows the last accepted write.

Top module: `dphy_cfg_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `wr_valid_o`, `busy_o` and `done_o` are all 0.
- R2: The VCO range is 0 for a lane rate below 200. Otherwise it is (rate + 100) / 200 with integer division. The write to address 0x10 carries data 0x83 with the VCO range placed in bits [5:3].
- R3: A VCO range above 7 is clamped to 7. For example, rates of 1500 and 4095 both give 0x10 data 0xBB.
- R4: On the primary instance (`primary_i`=1) the order of the 17 addresses is 0x10, 0x11, 0x12, 0x44, 0x17, 0x18, 0x19, 0x18, 0x19, 0x20, 0x21, 0x21, 0x22, 0x22, 0x70, 0x71, 0x72.
- R5: On a secondary instance (`primary_i`=0) the five PLL writes (0x17 through the second 0x19) are skipped, which leaves 12 writes.
- R6: Divider packing works as follows:
  - 0x17 carries the input divider's low 8 bits.
  - The first 0x18 carries 0x40 | feedback[4:0].
  - The second 0x18 carries 0x80 | feedback[8:5].
- R7: The fixed data values are:
  - 0x11=0x03 and 0x12=0xC1.
  - Both writes to 0x19 carry 0x30.
  - 0x20=0x0F.
  - 0x21 is written 0x4B, then 0x9D.
  - 0x22 is written 0x43, then 0x84.
  - 0x70=0x8F, 0x71=0xAD and 0x72=0x8A.
- R8: The write to 0x44 carries the frequency-range code's low 6 bits in bits [6:1], with bits 7 and 0 clear.
- R9: While `wr_valid_o` is 1 and `wr_ready_i` is 0, address, data and valid hold their values into the next cycle.
- R10: `done_o` is 1 for exactly one cycle, namely the cycle after the final write is accepted. In that cycle `busy_o` and `wr_valid_o` are 0.
- R11: A start pulse that arrives while a sequence is running has no effect: no extra writes and no extra done pulse.
- R12: All inputs are captured on the accepted start. Changes to them during a sequence do not alter its writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| lane_mbps_i | input | 12 | Lane bit rate in Mbps |
| hsfreq_i | input | 6 | High-speed frequency-range code |
| in_div_i | input | 8 | PLL input divider value |
| fb_div_i | input | 9 | PLL feedback divider value |
| primary_i | input | 1 | 1 = primary instance, enables PLL writes |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Downstream accepts the current write |
| wr_addr_o | output | 8 | Register address of the current write |
| wr_data_o | output | 8 | Register data of the current write |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after the last write |

## Verification
The bench builds the block with its default parameters: a 12-bit rate, a 3-bit VCO field, a 6-bit frequency code, an 8-bit input divider and a 9-bit feedback divider. The 12-bit rate lets the bench drive rates up to 4095, where the unclamped quotient reaches 20, so the clamp to 7 is exercised. The rounding edges at 199/200 and 299/300 are also exercised. The 9-bit feedback divider makes the high-half write carry nonzero bits. A pseudo-random ready pattern stretches writes so that hold-while-stalled is tested.

// File: rtl/dphy_cfg_pkg.sv
package dphy_cfg_pkg;

    localparam int unsigned STEP_COUNT = 17;
    localparam int unsigned STEP_W     = $clog2(STEP_COUNT);

    localparam logic [STEP_W-1:0] STEP_VCO      = STEP_W'(0);
    localparam logic [STEP_W-1:0] STEP_CP       = STEP_W'(1);
    localparam logic [STEP_W-1:0] STEP_LPF      = STEP_W'(2);
    localparam logic [STEP_W-1:0] STEP_HSFREQ   = STEP_W'(3);
    localparam logic [STEP_W-1:0] STEP_PLL_IDIV = STEP_W'(4);
    localparam logic [STEP_W-1:0] STEP_PLL_FBLO = STEP_W'(5);
    localparam logic [STEP_W-1:0] STEP_PLL_EN_A = STEP_W'(6);
    localparam logic [STEP_W-1:0] STEP_PLL_FBHI = STEP_W'(7);
    localparam logic [STEP_W-1:0] STEP_PLL_EN_B = STEP_W'(8);
    localparam logic [STEP_W-1:0] STEP_BIAS     = STEP_W'(9);
    localparam logic [STEP_W-1:0] STEP_TERM_LO  = STEP_W'(10);
    localparam logic [STEP_W-1:0] STEP_TERM_HI  = STEP_W'(11);
    localparam logic [STEP_W-1:0] STEP_BG_LO    = STEP_W'(12);
    localparam logic [STEP_W-1:0] STEP_BG_HI    = STEP_W'(13);
    localparam logic [STEP_W-1:0] STEP_T_LP     = STEP_W'(14);
    localparam logic [STEP_W-1:0] STEP_T_PRE    = STEP_W'(15);
    localparam logic [STEP_W-1:0] STEP_T_ZERO   = STEP_W'(16);
    localparam logic [STEP_W-1:0] STEP_LAST     = STEP_T_ZERO;

    // Register addresses (the receiving PHY decodes these)
    localparam logic [7:0] A_VCO    = 8'h10;
    localparam logic [7:0] A_CP     = 8'h11;
    localparam logic [7:0] A_LPF    = 8'h12;
    localparam logic [7:0] A_HSFREQ = 8'h44;
    localparam logic [7:0] A_IDIV   = 8'h17;
    localparam logic [7:0] A_FBDIV  = 8'h18;
    localparam logic [7:0] A_DIVEN  = 8'h19;
    localparam logic [7:0] A_BIAS   = 8'h20;
    localparam logic [7:0] A_TERM   = 8'h21;
    localparam logic [7:0] A_BGAP   = 8'h22;
    localparam logic [7:0] A_T_LP   = 8'h70;
    localparam logic [7:0] A_T_PRE  = 8'h71;
    localparam logic [7:0] A_T_ZERO = 8'h72;

    // Fixed data patterns and enable bits
    localparam logic [7:0] D_VCO_BASE = 8'h83;
    localparam logic [7:0] D_CP       = 8'h03;
    localparam logic [7:0] D_LPF      = 8'hC1;
    localparam logic [7:0] D_DIVEN    = 8'h30;
    localparam logic [7:0] D_BIAS     = 8'h0F;
    localparam logic [7:0] D_TERM_LO  = 8'h4B;
    localparam logic [7:0] D_TERM_HI  = 8'h9D;
    localparam logic [7:0] D_BG_LO    = 8'h43;
    localparam logic [7:0] D_BG_HI    = 8'h84;
    localparam logic [7:0] D_T_LP     = 8'h8F;
    localparam logic [7:0] D_T_PRE    = 8'hAD;
    localparam logic [7:0] D_T_ZERO   = 8'h8A;
    localparam logic [7:0] EN_LOW     = 8'h40;
    localparam logic [7:0] EN_HIGH    = 8'h80;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/dphy_vco_calc.sv
module dphy_vco_calc #(
    parameter int RATE_W    = 12,
    parameter int VCO_W     = 3,
    parameter int LOW_LIMIT = 200,
    parameter int BIAS      = 100,
    parameter int DIVISOR   = 200
) (
    input  logic [RATE_W-1:0] rate_i,
    output logic [VCO_W-1:0]  vco_o
);
    localparam int SUM_W   = RATE_W + 1;
    localparam int VCO_MAX = (1 << VCO_W) - 1;

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] quot;

    always_comb begin
        sum  = {1'b0, rate_i} + SUM_W'(BIAS);
        quot = sum / SUM_W'(DIVISOR);
        if ({1'b0, rate_i} < SUM_W'(LOW_LIMIT)) begin
            vco_o = '0;
        end else if (quot > SUM_W'(VCO_MAX)) begin
            vco_o = VCO_W'(VCO_MAX);
        end else begin
            vco_o = quot[VCO_W-1:0];
        end
    end
endmodule

// File: rtl/dphy_cfg_step_next.sv
module dphy_cfg_step_next
    import dphy_cfg_pkg::*;
(
    input  logic [STEP_W-1:0] step_i,
    input  logic              primary_i,
    output logic [STEP_W-1:0] next_o,
    output logic              last_o
);
    always_comb begin
        last_o = (step_i == STEP_LAST);
        if (step_i == STEP_HSFREQ && !primary_i) begin
            next_o = STEP_BIAS;
        end else begin
            next_o = step_i + STEP_W'(1);
        end
    end
endmodule

// File: rtl/dphy_cfg_rom.sv
module dphy_cfg_rom
    import dphy_cfg_pkg::*;
#(
    parameter int VCO_W   = 3,
    parameter int HSF_W   = 6,
    parameter int IDIV_W  = 8,
    parameter int FBDIV_W = 9
) (
    input  logic [STEP_W-1:0]  step_i,
    input  logic [VCO_W-1:0]   vco_i,
    input  logic [HSF_W-1:0]   hsf_i,
    input  logic [IDIV_W-1:0]  idiv_i,
    input  logic [FBDIV_W-1:0] fb_i,
    output logic [7:0]         addr_o,
    output logic [7:0]         data_o
);
    logic [VCO_W+7:0]   vco_ext;
    logic [HSF_W+7:0]   hsf_ext;
    logic [IDIV_W+7:0]  idiv_ext;
    logic [FBDIV_W+7:0] fb_ext;

    always_comb begin
        vco_ext  = {8'b0, vco_i};
        hsf_ext  = {8'b0, hsf_i};
        idiv_ext = {8'b0, idiv_i};
        fb_ext   = {8'b0, fb_i};
        addr_o   = A_VCO;
        data_o   = D_VCO_BASE;
        case (step_i)
            STEP_VCO: begin
                addr_o = A_VCO;
                data_o = D_VCO_BASE | {2'b00, vco_ext[2:0], 3'b000};
            end
            STEP_CP:       begin addr_o = A_CP;     data_o = D_CP;     end
            STEP_LPF:      begin addr_o = A_LPF;    data_o = D_LPF;    end
            STEP_HSFREQ: begin
                addr_o = A_HSFREQ;
                data_o = {1'b0, hsf_ext[5:0], 1'b0};
            end
            STEP_PLL_IDIV: begin addr_o = A_IDIV;   data_o = idiv_ext[7:0]; end
            STEP_PLL_FBLO: begin
                addr_o = A_FBDIV;
                data_o = EN_LOW | {3'b000, fb_ext[4:0]};
            end
            STEP_PLL_EN_A: begin addr_o = A_DIVEN;  data_o = D_DIVEN;  end
            STEP_PLL_FBHI: begin
                addr_o = A_FBDIV;
                data_o = EN_HIGH | {4'b0000, fb_ext[8:5]};
            end
            STEP_PLL_EN_B: begin addr_o = A_DIVEN;  data_o = D_DIVEN;  end
            STEP_BIAS:     begin addr_o = A_BIAS;   data_o = D_BIAS;   end
            STEP_TERM_LO:  begin addr_o = A_TERM;   data_o = D_TERM_LO; end
            STEP_TERM_HI:  begin addr_o = A_TERM;   data_o = D_TERM_HI; end
            STEP_BG_LO:    begin addr_o = A_BGAP;   data_o = D_BG_LO;  end
            STEP_BG_HI:    begin addr_o = A_BGAP;   data_o = D_BG_HI;  end
            STEP_T_LP:     begin addr_o = A_T_LP;   data_o = D_T_LP;   end
            STEP_T_PRE:    begin addr_o = A_T_PRE;  data_o = D_T_PRE;  end
            STEP_T_ZERO:   begin addr_o = A_T_ZERO; data_o = D_T_ZERO; end
            default: begin
                addr_o = A_VCO;
                data_o = D_VCO_BASE;
            end
        endcase
    end
endmodule

// File: rtl/dphy_cfg_seq.sv
module dphy_cfg_seq
    import dphy_cfg_pkg::*;
#(
    parameter int RATE_W  = 12,
    parameter int VCO_W   = 3,
    parameter int HSF_W   = 6,
    parameter int IDIV_W  = 8,
    parameter int FBDIV_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [RATE_W-1:0]  lane_mbps_i,
    input  logic [HSF_W-1:0]   hsfreq_i,
    input  logic [IDIV_W-1:0]  in_div_i,
    input  logic [FBDIV_W-1:0] fb_div_i,
    input  logic               primary_i,
    output logic               wr_valid_o,
    input  logic               wr_ready_i,
    output logic [7:0]         wr_addr_o,
    output logic [7:0]         wr_data_o,
    output logic               busy_o,
    output logic               done_o
);
    typedef struct packed {
        seq_state_e         state;
        logic [STEP_W-1:0]  step;
        logic [VCO_W-1:0]   vco;
        logic [HSF_W-1:0]   hsf;
        logic [IDIV_W-1:0]  idiv;
        logic [FBDIV_W-1:0] fb;
        logic               primary;
        logic               done;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    logic [VCO_W-1:0]  vco_now;
    logic [STEP_W-1:0] step_next;
    logic              step_last;

    dphy_vco_calc #(
        .RATE_W (RATE_W),
        .VCO_W  (VCO_W)
    ) u_vco (
        .rate_i (lane_mbps_i),
        .vco_o  (vco_now)
    );

    dphy_cfg_step_next u_next (
        .step_i    (seq_q.step),
        .primary_i (seq_q.primary),
        .next_o    (step_next),
        .last_o    (step_last)
    );

    dphy_cfg_rom #(
        .VCO_W   (VCO_W),
        .HSF_W   (HSF_W),
        .IDIV_W  (IDIV_W),
        .FBDIV_W (FBDIV_W)
    ) u_rom (
        .step_i (seq_q.step),
        .vco_i  (seq_q.vco),
        .hsf_i  (seq_q.hsf),
        .idiv_i (seq_q.idiv),
        .fb_i   (seq_q.fb),
        .addr_o (wr_addr_o),
        .data_o (wr_data_o)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.state)
            SEQ_IDLE: begin
                if (start_i) begin
                    seq_d.state   = SEQ_RUN;
                    seq_d.step    = STEP_VCO;
                    seq_d.vco     = vco_now;
                    seq_d.hsf     = hsfreq_i;
                    seq_d.idiv    = in_div_i;
                    seq_d.fb      = fb_div_i;
                    seq_d.primary = primary_i;
                end
            end
            SEQ_RUN: begin
                if (wr_ready_i) begin
                    if (step_last) begin
                        seq_d.state = SEQ_IDLE;
                        seq_d.step  = STEP_VCO;
                        seq_d.done  = 1'b1;
                    end else begin
                        seq_d.step = step_next;
                    end
                end
            end
            default: seq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign wr_valid_o = (seq_q.state == SEQ_RUN);
    assign busy_o     = (seq_q.state == SEQ_RUN);
    assign done_o     = seq_q.done;
endmodule

// File: rtl/dphy_cfg_seq_chk.sv
module dphy_cfg_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       wr_valid_o,
    input logic       wr_ready_i,
    input logic [7:0] wr_addr_o,
    input logic [7:0] wr_data_o,
    input logic       busy_o,
    input logic       done_o
);
    assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=>
            (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!wr_valid_o && !busy_o));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(wr_valid_o && wr_ready_i && (wr_addr_o == 8'h72)));

    assert_vco_fixed_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && wr_addr_o == 8'h10) |->
            (wr_data_o[7] && wr_data_o[6] == 1'b0 && wr_data_o[2:0] == 3'b011));

    assert_first_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (wr_addr_o == 8'h10));

    assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !(wr_ready_i && wr_addr_o == 8'h72)) |=> busy_o);
endmodule

bind dphy_cfg_seq dphy_cfg_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .wr_valid_o (wr_valid_o),
    .wr_ready_i (wr_ready_i),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/dphy_cfg_seq_tb.sv
module dphy_cfg_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [11:0] lane_mbps_i = '0;
    logic [5:0] hsfreq_i = '0;
    logic [7:0] in_div_i = '0;
    logic [8:0] fb_div_i = '0;
    logic       primary_i = 1'b0;
    logic       wr_valid_o;
    logic       wr_ready_i = 1'b1;
    logic [7:0] wr_addr_o;
    logic [7:0] wr_data_o;
    logic       busy_o;
    logic       done_o;

    always #10 clk = ~clk;

    dphy_cfg_seq u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .lane_mbps_i (lane_mbps_i),
        .hsfreq_i    (hsfreq_i),
        .in_div_i    (in_div_i),
        .fb_div_i    (fb_div_i),
        .primary_i   (primary_i),
        .wr_valid_o  (wr_valid_o),
        .wr_ready_i  (wr_ready_i),
        .wr_addr_o   (wr_addr_o),
        .wr_data_o   (wr_data_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 1'b0;

    bit stall_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    logic [7:0] log_a [0:31];
    logic [7:0] log_d [0:31];
    int log_n = 0;
    int done_n = 0;
    int last_hs = 0;
    int done_gap = 0;
    bit prev_stall = 1'b0;
    logic [7:0] prev_a = '0;
    logic [7:0] prev_d = '0;

    logic [7:0] ea [0:31];
    logic [7:0] ed [0:31];
    int en = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // ready pattern, changed well after the edge
    always @(posedge clk) begin
        #2;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        wr_ready_i = stall_mode ? lfsr[0] : 1'b1;
    end

    // monitor on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                chk(wr_valid_o && wr_addr_o == prev_a && wr_data_o == prev_d,
                    "R9", "held during stall", {wr_addr_o, wr_data_o}, {prev_a, prev_d});
            end
            prev_stall = wr_valid_o && !wr_ready_i;
            prev_a = wr_addr_o;
            prev_d = wr_data_o;
            if (wr_valid_o && wr_ready_i) begin
                if (log_n < 32) begin
                    log_a[log_n] = wr_addr_o;
                    log_d[log_n] = wr_data_o;
                end
                log_n++;
                last_hs = cyc;
            end
            if (done_o) begin
                done_n++;
                done_gap = cyc - last_hs;
            end
        end
    end

    function automatic int exp_vco(input int r);
        int v;
        if (r < 200) return 0;
        v = (r + 100) / 200;
        return (v > 7) ? 7 : v;
    endfunction

    task automatic push(input logic [7:0] a, input logic [7:0] d);
        ea[en] = a;
        ed[en] = d;
        en++;
    endtask

    task automatic build_exp(input bit prim, input int rate, input int hsf,
                             input int idiv, input int fb);
        logic [7:0] v;
        logic [8:0] f;
        logic [5:0] h;
        en = 0;
        v = 8'(exp_vco(rate));
        f = fb[8:0];
        h = hsf[5:0];
        push(8'h10, 8'h83 | (v << 3));
        push(8'h11, 8'h03);
        push(8'h12, 8'hC1);
        push(8'h44, {1'b0, h, 1'b0});
        if (prim) begin
            push(8'h17, idiv[7:0]);
            push(8'h18, 8'h40 | {3'b000, f[4:0]});
            push(8'h19, 8'h30);
            push(8'h18, 8'h80 | {4'b0000, f[8:5]});
            push(8'h19, 8'h30);
        end
        push(8'h20, 8'h0F);
        push(8'h21, 8'h4B);
        push(8'h21, 8'h9D);
        push(8'h22, 8'h43);
        push(8'h22, 8'h84);
        push(8'h70, 8'h8F);
        push(8'h71, 8'hAD);
        push(8'h72, 8'h8A);
    endtask

    task automatic compare(input bit prim, input int rate, input int hsf,
                           input int idiv, input int fb, input string ctx,
                           input string vco_req);
        string rq;
        build_exp(prim, rate, hsf, idiv, fb);
        chk(log_n == en, prim ? "R4" : "R5", {ctx, " write count"}, log_n, en);
        for (int i = 0; i < en && i < log_n; i++) begin
            case (ea[i])
                8'h10:        rq = vco_req;
                8'h44:        rq = "R8";
                8'h17, 8'h18: rq = "R6";
                default:      rq = "R7";
            endcase
            chk(log_a[i] == ea[i], prim ? "R4" : "R5", {ctx, " address order"},
                log_a[i], ea[i]);
            chk(log_d[i] == ed[i], rq, {ctx, " data"}, log_d[i], ed[i]);
        end
        chk(done_n == 1, "R10", {ctx, " done pulses"}, done_n, 1);
        chk(done_gap == 1, "R10", {ctx, " done delay"}, done_gap, 1);
        chk(!busy_o && !wr_valid_o, "R10", {ctx, " idle after done"},
            {busy_o, wr_valid_o}, 0);
    endtask

    task automatic launch(input bit prim, input int rate, input int hsf,
                          input int idiv, input int fb, input bit stall);
        @(negedge clk);
        primary_i   = prim;
        lane_mbps_i = rate[11:0];
        hsfreq_i    = hsf[5:0];
        in_div_i    = idiv[7:0];
        fb_div_i    = fb[8:0];
        stall_mode  = stall;
        log_n       = 0;
        done_n      = 0;
        start_i     = 1'b1;
        @(negedge clk);
        start_i     = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000 && done_n == 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_seq(input bit prim, input int rate, input int hsf,
                           input int idiv, input int fb, input bit stall,
                           input string ctx, input string vco_req);
        launch(prim, rate, hsf, idiv, fb, stall);
        wait_done();
        compare(prim, rate, hsf, idiv, fb, ctx, vco_req);
    endtask

    task automatic test_reset_R1();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!wr_valid_o && !busy_o && !done_o, "R1", "outputs in reset",
            {wr_valid_o, busy_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!wr_valid_o && !busy_o && !done_o, "R1", "outputs after reset",
            {wr_valid_o, busy_o, done_o}, 0);
    endtask

    task automatic test_primary_R4();
        run_seq(1'b1, 1000, 6'h2A, 8'h5C, 9'h1B7, 1'b0, "primary", "R2");
    endtask

    task automatic test_secondary_stall_R5();
        run_seq(1'b0, 150, 6'h15, 8'h11, 9'h0F0, 1'b1, "secondary stalled", "R2");
        run_seq(1'b1, 640, 6'h3F, 8'hFF, 9'h1FF, 1'b1, "primary stalled", "R2");
    endtask

    task automatic test_vco_edges_R2();
        run_seq(1'b0, 199, 6'h01, 8'h01, 9'h001, 1'b0, "rate 199", "R2");
        run_seq(1'b0, 200, 6'h01, 8'h01, 9'h001, 1'b0, "rate 200", "R2");
        run_seq(1'b0, 299, 6'h01, 8'h01, 9'h001, 1'b0, "rate 299", "R2");
        run_seq(1'b0, 300, 6'h01, 8'h01, 9'h001, 1'b0, "rate 300", "R2");
        run_seq(1'b0, 1300, 6'h01, 8'h01, 9'h001, 1'b0, "rate 1300", "R2");
    endtask

    task automatic test_saturate_R3();
        run_seq(1'b0, 1500, 6'h0C, 8'h02, 9'h020, 1'b0, "rate 1500", "R3");
        run_seq(1'b1, 4095, 6'h0C, 8'h02, 9'h020, 1'b0, "rate 4095", "R3");
    endtask

    task automatic test_restart_ignored_R11();
        launch(1'b1, 800, 6'h07, 8'h33, 9'h155, 1'b1);
        for (int i = 0; i < 500 && log_n < 3; i++) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        repeat (30) @(negedge clk);
        compare(1'b1, 800, 6'h07, 8'h33, 9'h155, "R11 restart mid-run", "R2");
        chk(log_n == 17, "R11", "no extra writes", log_n, 17);
    endtask

    task automatic test_capture_R12();
        launch(1'b1, 520, 6'h19, 8'h44, 9'h0AB, 1'b1);
        lane_mbps_i = 12'd3000;
        primary_i   = 1'b0;
        hsfreq_i    = 6'h3C;
        in_div_i    = 8'hEE;
        fb_div_i    = 9'h1E1;
        wait_done();
        compare(1'b1, 520, 6'h19, 8'h44, 9'h0AB, "R12 inputs changed mid-run", "R2");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        test_reset_R1();
        test_primary_R4();
        test_secondary_stall_R5();
        test_vco_edges_R2();
        test_saturate_R3();
        test_restart_ignored_R11();
        test_capture_R12();
        finish_up();
    end
endmodule